// File: doc/BRIEF.md
# Optical Module Management Register Bank

This block is the byte-addressed management memory of a pluggable optical transceiver. A host reaches it through a simple byte port. A load strobe selects one of two 256-byte pages (identification or diagnostics) and a starting offset. Each later read or write strobe accesses the byte under an internal pointer and then advances the pointer. The identification page is fixed at build time. Its two check bytes are sums that the block computes itself. The diagnostic page holds read-only 16-bit threshold words, five live 16-bit measurement words taken from input ports, a status/control byte and a user-writable scratch area.

The status/control byte shows the synchronized state of the module pins and holds two software override bits. These bits are ORed into the transmit-disable and rate-select outputs. A most-significant-byte read of any 16-bit word also latches the companion low byte, so a two-byte read always returns one coherent sample. A data-not-ready flag stays set for a parameterized number of cycles after reset.

Top module: `xcvr_mgmt_bank`

## Requirements
- R1: After reset the pointer is offset 0 of the identification page, both soft override bits are 0, and the data-not-ready flag (status bit 0) is 1.
- R2: Identification page offsets 0..127 return the build-time contents from the package function `id_rom_byte`, except offsets 63 and 95. Offset 0 reads 0x03 and offset 92 reads 0x60, i.e. bit 6 (monitoring present) and bit 5 (internal calibration) are set. Offsets 96..255 read 0.
- R3: Identification offset 63 reads the low 8 bits of the sum of identification bytes 0..62.
- R4: Identification offset 95 reads the low 8 bits of the sum of identification bytes 64..94.
- R5: `host_set` loads page and offset, and no access takes place in that cycle. Each read or write strobe advances the offset by one after the access, and the offset wraps from 255 to 0 within the same page. Read data appears on `host_rdata` on the clock edge that takes the read strobe.
- R6: Diagnostic offsets 128..247 are user storage: a byte written there reads back unchanged.
- R7: Writes to any identification byte, to any diagnostic byte outside 128..247 and 110, are ignored.
- R8: Diagnostic offsets 0..39 hold 20 threshold words whose bytes come from the package function `thr_byte`. Offsets 96..105 hold the live words `meas_in[16k+:16]` at offset 96+2k. Every word is stored high byte at the even offset. Reading an even offset of a word latches that word's low byte. An immediately following read of the odd offset returns the latched byte, even if the word has changed in between.
- R9: Status byte at diagnostic offset 110 reads {tx-disable pin, soft tx-disable, rs1 pin, rate-select pin, soft rate-select, tx-fault pin, rx-los pin, data-not-ready} from bit 7 down to bit 0. The pin bits follow their pins through a two-flop synchronizer.
- R10: Only bits 6 and 3 of offset 110 are writable; writing other bits changes nothing.
- R11: `tx_disable_out` is `pin_tx_disable` OR soft bit 6, and `rate_sel_out` is `pin_rate_sel` OR soft bit 3, for every combination.
- R12: Data-not-ready falls READY_CYCLES clocks after reset is released and never rises again before the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_set | input | 1 | Load page and offset |
| host_page | input | 1 | 0 identification page, 1 diagnostic page |
| host_ofs | input | 8 | Start offset loaded by host_set |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| meas_in | input | 80 | Five live 16-bit measurement words, word k at bits 16k+15..16k |
| pin_tx_disable | input | 1 | Hard transmit-disable pin |
| pin_rs1 | input | 1 | Second rate-select pin |
| pin_rate_sel | input | 1 | Hard rate-select pin |
| pin_tx_fault | input | 1 | Transmit fault pin |
| pin_rx_los | input | 1 | Receive loss-of-signal pin |
| tx_disable_out | output | 1 | Effective transmit disable |
| rate_sel_out | output | 1 | Effective rate select |

## Verification
The hardest case to reach from the ports is a torn 16-bit read. The live word has to change in exactly the window between the high-byte read and the low-byte read. The bench drives a new value on `meas_in` after the high-byte read has been registered and before the low-byte strobe is issued. It then expects the old low byte. A fresh load that points straight at the odd offset must see the new one. The OR outputs are walked through all four pin and soft-bit combinations, with the soft bits set through ordinary writes to the status byte.

// File: rtl/xcvr_mgmt_pkg.sv
package xcvr_mgmt_pkg;

    localparam int THR_BYTES   = 40;
    localparam int MEAS_BASE   = 96;
    localparam int STATUS_OFS  = 110;
    localparam int USER_LO     = 128;
    localparam int USER_HI     = 247;
    localparam int CSUM_BASE   = 63;
    localparam int CSUM_EXT    = 95;

    // Build-time identification contents (check bytes filled by logic).
    function automatic logic [7:0] id_rom_byte(input logic [7:0] o);
        if (o == 8'd0)  return 8'h03;
        if (o == 8'd92) return 8'h60;
        if (o == 8'd63 || o == 8'd95) return 8'h00;
        if (o < 8'd96)  return 8'(int'(o) * 37 + 11);
        return 8'h00;
    endfunction

    // Build-time threshold bytes.
    function automatic logic [7:0] thr_byte(input logic [7:0] o);
        return 8'(8'hA5 ^ 8'(int'(o) * 3));
    endfunction

    typedef struct packed {
        logic       page;
        logic [7:0] ptr;
        logic [7:0] rdata;
        logic       soft_txdis;
        logic       soft_rate;
        logic [7:0] shadow;
        logic [7:0] shadow_ofs;
        logic       shadow_vld;
        logic       not_ready;
    } bank_state_t;

endpackage

// File: rtl/xmb_sync.sv
module xmb_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_in[i];
                stab_q <= meta_q;
            end
        end
        assign sync_out[i] = stab_q;
    end
endmodule

// File: rtl/xmb_id_page.sv
module xmb_id_page
    import xcvr_mgmt_pkg::*;
(
    input  logic [7:0] ofs,
    output logic [7:0] data
);
    logic [7:0] sum_base, sum_ext;

    always_comb begin
        sum_base = 8'h00;
        sum_ext  = 8'h00;
        for (int i = 0; i < CSUM_BASE; i++)
            sum_base = sum_base + id_rom_byte(8'(i));
        for (int i = CSUM_BASE + 1; i < CSUM_EXT; i++)
            sum_ext = sum_ext + id_rom_byte(8'(i));
        if (ofs == 8'(CSUM_BASE))     data = sum_base;
        else if (ofs == 8'(CSUM_EXT)) data = sum_ext;
        else                          data = id_rom_byte(ofs);
    end
endmodule

// File: rtl/xmb_user_ram.sv
module xmb_user_ram #(
    parameter int BASE  = 128,
    parameter int DEPTH = 120
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]    mem_q [DEPTH];
    logic [AW-1:0] idx;

    assign idx   = AW'(addr - 8'(BASE));
    assign rdata = mem_q[idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end
endmodule

// File: rtl/xcvr_mgmt_bank.sv
module xcvr_mgmt_bank
    import xcvr_mgmt_pkg::*;
#(
    parameter int NUM_MEAS     = 5,
    parameter int READY_CYCLES = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_set,
    input  logic                  host_page,
    input  logic [7:0]            host_ofs,
    input  logic                  host_rd,
    input  logic                  host_wr,
    input  logic [7:0]            host_wdata,
    output logic [7:0]            host_rdata,
    input  logic [NUM_MEAS*16-1:0] meas_in,
    input  logic                  pin_tx_disable,
    input  logic                  pin_rs1,
    input  logic                  pin_rate_sel,
    input  logic                  pin_tx_fault,
    input  logic                  pin_rx_los,
    output logic                  tx_disable_out,
    output logic                  rate_sel_out
);
    localparam int MEAS_W  = NUM_MEAS * 16;
    localparam int MEAS_HI = MEAS_BASE + 2 * NUM_MEAS;
    localparam int CNT_W   = $clog2(READY_CYCLES + 1);

    bank_state_t      st_d, st_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [4:0]       pins_s;
    logic [7:0]       id_byte, user_byte, cur_byte, status_byte;
    logic             user_hit, user_we;

    // Signals exposed to the bound checker.
    logic [7:0] ptr_q;
    logic       soft_txdis_q, soft_rate_q, not_ready_q;
    assign ptr_q        = st_q.ptr;
    assign soft_txdis_q = st_q.soft_txdis;
    assign soft_rate_q  = st_q.soft_rate;
    assign not_ready_q  = st_q.not_ready;

    function automatic logic is_word(input logic [7:0] o);
        return (o < 8'(THR_BYTES)) || (o >= 8'(MEAS_BASE) && o < 8'(MEAS_HI));
    endfunction

    function automatic logic [7:0] diag_ro(input logic [7:0] o,
                                           input logic [MEAS_W-1:0] m);
        logic [15:0] w;
        int          k;
        if (o < 8'(THR_BYTES)) return thr_byte(o);
        if (o >= 8'(MEAS_BASE) && o < 8'(MEAS_HI)) begin
            k = (int'(o) - MEAS_BASE) / 2;
            w = m[k*16 +: 16];
            return o[0] ? w[7:0] : w[15:8];
        end
        return 8'h00;
    endfunction

    xmb_sync #(.W(5)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({pin_tx_disable, pin_rs1, pin_rate_sel, pin_tx_fault, pin_rx_los}),
        .sync_out (pins_s)
    );

    xmb_id_page u_id (
        .ofs  (st_q.ptr),
        .data (id_byte)
    );

    assign user_hit = st_q.page && st_q.ptr >= 8'(USER_LO) && st_q.ptr <= 8'(USER_HI);
    assign user_we  = host_wr && !host_set && user_hit;

    xmb_user_ram #(.BASE(USER_LO), .DEPTH(USER_HI - USER_LO + 1)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (user_we),
        .addr  (st_q.ptr),
        .wdata (host_wdata),
        .rdata (user_byte)
    );

    assign status_byte = {pins_s[4], st_q.soft_txdis, pins_s[3], pins_s[2],
                          st_q.soft_rate, pins_s[1], pins_s[0], st_q.not_ready};

    always_comb begin
        if (!st_q.page)                         cur_byte = id_byte;
        else if (user_hit)                      cur_byte = user_byte;
        else if (st_q.ptr == 8'(STATUS_OFS))    cur_byte = status_byte;
        else                                    cur_byte = diag_ro(st_q.ptr, meas_in);
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (st_q.not_ready) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(READY_CYCLES - 1)) st_d.not_ready = 1'b0;
        end
        if (host_set) begin
            st_d.page       = host_page;
            st_d.ptr        = host_ofs;
            st_d.shadow_vld = 1'b0;
        end else begin
            if (host_rd || host_wr) st_d.ptr = st_q.ptr + 8'd1;
            if (host_rd) begin
                st_d.shadow_vld = 1'b0;
                if (st_q.page && st_q.shadow_vld && st_q.ptr == st_q.shadow_ofs)
                    st_d.rdata = st_q.shadow;
                else
                    st_d.rdata = cur_byte;
                if (st_q.page && is_word(st_q.ptr) && !st_q.ptr[0]) begin
                    st_d.shadow     = diag_ro(st_q.ptr + 8'd1, meas_in);
                    st_d.shadow_ofs = st_q.ptr + 8'd1;
                    st_d.shadow_vld = 1'b1;
                end
            end
            if (host_wr && st_q.page && st_q.ptr == 8'(STATUS_OFS)) begin
                st_d.soft_txdis = host_wdata[6];
                st_d.soft_rate  = host_wdata[3];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.not_ready <= 1'b1;
            cnt_q          <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign host_rdata     = st_q.rdata;
    assign tx_disable_out = pin_tx_disable | st_q.soft_txdis;
    assign rate_sel_out   = pin_rate_sel | st_q.soft_rate;

endmodule

// File: rtl/xmb_checker.sv
module xmb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       host_set,
    input logic       host_rd,
    input logic       host_wr,
    input logic [7:0] ptr_q,
    input logic       soft_txdis_q,
    input logic       soft_rate_q,
    input logic       not_ready_q,
    input logic       pin_tx_disable,
    input logic       pin_rate_sel,
    input logic       tx_disable_out,
    input logic       rate_sel_out
);
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_set && (host_rd || host_wr)) |=> ptr_q == $past(ptr_q) + 8'd1);

    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_set && !host_rd && !host_wr) |=> $stable(ptr_q));

    p_soft_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> ($stable(soft_txdis_q) && $stable(soft_rate_q)));

    p_ready_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !not_ready_q |=> !not_ready_q);

    p_txdis_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pin_tx_disable |-> tx_disable_out);

    p_rate_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rate_sel |-> rate_sel_out);
endmodule

bind xcvr_mgmt_bank xmb_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_set       (host_set),
    .host_rd        (host_rd),
    .host_wr        (host_wr),
    .ptr_q          (ptr_q),
    .soft_txdis_q   (soft_txdis_q),
    .soft_rate_q    (soft_rate_q),
    .not_ready_q    (not_ready_q),
    .pin_tx_disable (pin_tx_disable),
    .pin_rate_sel   (pin_rate_sel),
    .tx_disable_out (tx_disable_out),
    .rate_sel_out   (rate_sel_out)
);

// File: tb/sim_xcvr_mgmt_bank.sv
module sim_xcvr_mgmt_bank;
    import xcvr_mgmt_pkg::*;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        host_set = 0, host_page = 0, host_rd = 0, host_wr = 0;
    logic [7:0]  host_ofs = 0, host_wdata = 0;
    logic [7:0]  host_rdata;
    logic [79:0] meas_in = '0;
    logic        p_txd = 0, p_rs1 = 0, p_rate = 0, p_flt = 0, p_los = 0;
    logic        tx_disable_out, rate_sel_out;
    int          n_chk = 0, n_fail = 0;
    logic        done = 0;

    always #2 clk = ~clk;

    xcvr_mgmt_bank #(.NUM_MEAS(5), .READY_CYCLES(40)) u0 (
        .clk(clk), .rst_n(rst_n), .host_set(host_set), .host_page(host_page),
        .host_ofs(host_ofs), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .meas_in(meas_in),
        .pin_tx_disable(p_txd), .pin_rs1(p_rs1), .pin_rate_sel(p_rate),
        .pin_tx_fault(p_flt), .pin_rx_los(p_los),
        .tx_disable_out(tx_disable_out), .rate_sel_out(rate_sel_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic set_ptr(input logic pg, input logic [7:0] o);
        @(negedge clk); host_set = 1; host_page = pg; host_ofs = o;
        @(negedge clk); host_set = 0;
    endtask

    task automatic rd(output logic [7:0] d);
        @(negedge clk); host_rd = 1;
        @(negedge clk); host_rd = 0; d = host_rdata;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); host_wr = 1; host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_status(input logic st, input logic sr, input logic nr);
        return {p_txd, st, p_rs1, p_rate, sr, p_flt, p_los, nr};
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        rd(d); check("R1 ptr at id offset 0", d, 8'h03);
        set_ptr(1, 8'd110); rd(d);
        check("R1 status after reset", d, exp_status(0, 0, 1));
        check("R1 tx_disable_out", {7'd0, tx_disable_out}, 8'd0);
    endtask

    task automatic t_id_page();
        logic [7:0] d, s0, s1;
        s0 = 0; s1 = 0;
        for (int i = 0; i < 63; i++) s0 = s0 + id_rom_byte(8'(i));
        for (int i = 64; i < 95; i++) s1 = s1 + id_rom_byte(8'(i));
        set_ptr(0, 8'd0);
        for (int i = 0; i < 128; i++) begin
            rd(d);
            if (i == 63)      check("R3 base check byte", d, s0);
            else if (i == 95) check("R4 ext check byte", d, s1);
            else              check("R2/R5 id byte sequential", d, id_rom_byte(8'(i)));
        end
        set_ptr(0, 8'd92); rd(d); check("R2 diag type byte", d, 8'h60);
        set_ptr(0, 8'd200); rd(d); check("R2 upper id zero", d, 8'h00);
    endtask

    task automatic t_wrap();
        logic [7:0] d;
        set_ptr(0, 8'd255); rd(d); check("R5 offset 255", d, 8'h00);
        rd(d); check("R5 wrap to 0", d, 8'h03);
        set_ptr(0, 8'd5); host_rd = 1; @(negedge clk); host_rd = 0;
        set_ptr(0, 8'd6); rd(d); check("R5 set overrides", d, id_rom_byte(8'd6));
    endtask

    task automatic t_user();
        logic [7:0] d;
        set_ptr(1, 8'd128);
        for (int i = 0; i < 4; i++) wr(8'(8'h50 + i));
        set_ptr(1, 8'd247); wr(8'hC7); wr(8'h99);
        set_ptr(1, 8'd128);
        for (int i = 0; i < 4; i++) begin rd(d); check("R6 user byte", d, 8'(8'h50 + i)); end
        set_ptr(1, 8'd247); rd(d); check("R6 user last byte", d, 8'hC7);
        rd(d); check("R7 offset 248 not writable", d, 8'h00);
    endtask

    task automatic t_readonly();
        logic [7:0] d;
        set_ptr(0, 8'd5); wr(8'h00);
        set_ptr(0, 8'd5); rd(d); check("R7 id write ignored", d, id_rom_byte(8'd5));
        set_ptr(1, 8'd2); wr(8'h00);
        set_ptr(1, 8'd2); rd(d); check("R7 threshold write ignored", d, thr_byte(8'd2));
        set_ptr(1, 8'd96); wr(8'h00);
        set_ptr(1, 8'd96); rd(d); check("R7 live write ignored", d, meas_in[15:8]);
    endtask

    task automatic t_tear();
        logic [7:0] d;
        meas_in[15:0]  = 16'h1234;
        meas_in[63:48] = 16'hABCD;
        set_ptr(1, 8'd96); rd(d); check("R8 live msb", d, 8'h12);
        meas_in[15:0] = 16'h5678;
        rd(d); check("R8 shadowed lsb", d, 8'h34);
        set_ptr(1, 8'd97); rd(d); check("R8 fresh lsb no shadow", d, 8'h78);
        set_ptr(1, 8'd102); rd(d); check("R8 word 3 msb", d, 8'hAB);
        rd(d); check("R8 word 3 lsb", d, 8'hCD);
        set_ptr(1, 8'd38); rd(d); check("R8 threshold msb", d, thr_byte(8'd38));
        rd(d); check("R8 threshold lsb", d, thr_byte(8'd39));
    endtask

    task automatic t_status();
        logic [7:0] d;
        for (int v = 0; v < 32; v += 7) begin
            {p_txd, p_rs1, p_rate, p_flt, p_los} = 5'(v);
            idle(4);
            set_ptr(1, 8'd110); rd(d);
            check("R9/R12 status mirror", d, exp_status(0, 0, 0));
        end
        set_ptr(1, 8'd110); wr(8'hFF);
        set_ptr(1, 8'd110); rd(d); check("R10 only bits 6,3 written", d, exp_status(1, 1, 0));
        set_ptr(1, 8'd110); wr(8'hB7);
        set_ptr(1, 8'd110); rd(d); check("R10 clear soft bits", d, exp_status(0, 0, 0));
    endtask

    task automatic t_or();
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 2; s++) begin
                p_txd = p[0]; p_rate = p[0];
                set_ptr(1, 8'd110); wr(s[0] ? 8'h48 : 8'h00);
                check("R11 tx_disable_out", {7'd0, tx_disable_out}, {7'd0, p[0] | s[0]});
                check("R11 rate_sel_out", {7'd0, rate_sel_out}, {7'd0, p[0] | s[0]});
                p_txd = s[0]; p_rate = 1'b0; @(negedge clk);
                check("R11 mixed tx", {7'd0, tx_disable_out}, {7'd0, 1'b1 & (s[0] | s[0])});
                check("R11 mixed rate", {7'd0, rate_sel_out}, {7'd0, s[0]});
            end
        end
        set_ptr(1, 8'd110); wr(8'h00); p_txd = 0; p_rate = 0;
    endtask

    initial begin
        idle(3); rst_n = 1;
        t_reset();
        t_id_page();
        t_wrap();
        t_user();
        t_readonly();
        t_tear();
        t_status();
        t_or();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule